// File: doc/BRIEF.md
# Serial Bus CRC Checker

This block keeps a running cyclic redundancy check over the bit stream of a single-wire serial bus master. The bus timing logic hands it one strobe per bus bit, together with the bit value and a direction flag telling whether the master drove the bit (write) or sampled it from a slave (read). Software picks an 8-bit or a 16-bit polynomial at run time. It opens accumulation for the write direction, the read direction, or both, each with its own enable.

After the frame's check bytes have gone through the register, software issues a compare command. The block then evaluates the residue, reports pass or fail on a mismatch flag, clears the command bit and raises a sticky completion flag. Software clears that flag by writing one to it.

Both polynomials are shifted least-significant bit first in reflected form. The 8-bit check expects a zero residue after the plain check byte. The 16-bit check expects the fixed residue that results from appending the inverted check value, low byte first.

Top module: `owcrc_checker`

## Requirements
- R1: After reset, the polynomial select, both enables, the compare-busy bit, the mismatch bit and the completion flag read 0, and the check register reads 0.
- R2: With the 8-bit polynomial selected (cfg_crc16=0), each accepted bit b updates the register as fb = crc[0]^b, crc[7:0] = (crc[7:0]>>1) ^ (fb ? 8'h8C : 0), and crc[15:8] reads 0.
- R3: With the 16-bit polynomial selected (cfg_crc16=1), each accepted bit b updates the register as fb = crc[0]^b, crc = (crc>>1) ^ (fb ? 16'hA001 : 0).
- R4: A strobe with bit_dir=1 (written bit) updates the register only when the write enable is set. Otherwise the register keeps its value.
- R5: A strobe with bit_dir=0 (read bit) updates the register only when the read enable is set. Otherwise the register keeps its value.
- R6: A configuration write that sets at least one enable while both enables are clear zeroes the register. A configuration write made while an enable is already set leaves the register's value unchanged.
- R7: A configuration write with cfg_check=1 sets the compare-busy bit at the next edge. One cycle later the busy bit clears, the completion flag sets, and the mismatch bit reads 0 exactly when the register holds 16'hB001 (16-bit mode) or 8'h00 in its low byte (8-bit mode).
- R8: The mismatch bit is cleared when a compare starts, and otherwise changes only when a compare finishes.
- R9: The completion flag stays set until done_clr is pulsed. If a compare finishes in the same cycle as the pulse, the flag stays set.
- R10: Bit strobes that arrive while a compare is busy do not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_crc16 | input | 1 | 1 selects the 16-bit polynomial, 0 the 8-bit |
| cfg_tx_en | input | 1 | Enable accumulation of written bits |
| cfg_rx_en | input | 1 | Enable accumulation of read bits |
| cfg_check | input | 1 | Write 1 to start a compare |
| done_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| bit_vld | input | 1 | One-cycle strobe per bus bit |
| bit_val | input | 1 | Bus bit value |
| bit_dir | input | 1 | 1 for a written bit, 0 for a read bit |
| stat_crc16 | output | 1 | Current polynomial select |
| stat_tx_en | output | 1 | Current write-direction enable |
| stat_rx_en | output | 1 | Current read-direction enable |
| stat_busy | output | 1 | Compare command bit, self-clearing |
| stat_mismatch | output | 1 | Result of the last compare, 1 on mismatch |
| irq_done | output | 1 | Sticky compare-completion flag |
| crc_q | output | 16 | Check register contents |

## Verification
Several properties are checked on every cycle. A compare stays busy for exactly one cycle and is always followed by the completion flag. The mismatch bit moves only at compare start and finish. The register holds still when no strobe or write arrives and while a compare runs, and a clear pulse drops an idle completion flag.

The polynomial arithmetic needs the bench's scenarios. Sweeps over every byte value in both modes check it, as do frames closed with their true or corrupted check bytes. The same scenarios cover the direction gating, the clear-on-enable rule and the pass/fail verdicts.

// File: rtl/owcrc_pkg.sv
package owcrc_pkg;
  localparam int CRC_W      = 16;
  localparam int CRC8_W     = 8;
  localparam logic [CRC8_W-1:0] POLY8_REFL  = 8'h8C;
  localparam logic [CRC_W-1:0]  POLY16_REFL = 16'hA001;
  localparam logic [CRC8_W-1:0] RESID8      = 8'h00;
  localparam logic [CRC_W-1:0]  RESID16     = 16'hB001;

  typedef enum logic [0:0] {CMP_IDLE = 1'b0, CMP_EVAL = 1'b1} cmp_state_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic b,
                                                input logic wide);
    logic fb;
    logic [CRC8_W-1:0] n8;
    logic [CRC_W-1:0] n16;
    fb  = cur[0] ^ b;
    n8  = cur[CRC8_W-1:0] >> 1;
    n16 = cur >> 1;
    if (fb) begin
      n8  = n8 ^ POLY8_REFL;
      n16 = n16 ^ POLY16_REFL;
    end
    crc_step = wide ? n16 : {{(CRC_W-CRC8_W){1'b0}}, n8};
  endfunction
endpackage

// File: rtl/owcrc_ctrl.sv
module owcrc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_crc16,
  input  logic cfg_tx_en,
  input  logic cfg_rx_en,
  input  logic cfg_check,
  input  logic bit_vld,
  input  logic bit_dir,
  input  logic busy,
  output logic mode16,
  output logic tx_en,
  output logic rx_en,
  output logic clr_req,
  output logic start_req,
  output logic accept
);
  logic any_on;

  always_comb begin
    any_on    = tx_en | rx_en;
    clr_req   = cfg_we & ~any_on & (cfg_tx_en | cfg_rx_en);
    start_req = cfg_we & cfg_check & ~busy;
    accept    = bit_vld & ~busy & (bit_dir ? tx_en : rx_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode16 <= 1'b0;
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
    end else if (cfg_we) begin
      mode16 <= cfg_crc16;
      tx_en  <= cfg_tx_en;
      rx_en  <= cfg_rx_en;
    end
  end
endmodule

// File: rtl/owcrc_shift.sv
module owcrc_shift
  import owcrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             din,
  input  logic             mode16,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (step)  crc <= crc_step(crc, din, mode16);
  end
endmodule

// File: rtl/owcrc_cmp.sv
module owcrc_cmp
  import owcrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode16,
  input  logic [CRC_W-1:0] crc,
  input  logic             done_clr,
  output logic             busy,
  output logic             mismatch,
  output logic             done
);
  cmp_state_t state;
  logic       bad;

  always_comb begin
    if (mode16) bad = (crc != RESID16);
    else        bad = (crc[CRC8_W-1:0] != RESID8);
  end

  assign busy = (state == CMP_EVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CMP_IDLE;
      mismatch <= 1'b0;
      done     <= 1'b0;
    end else begin
      case (state)
        CMP_IDLE: begin
          if (done_clr) done <= 1'b0;
          if (start) begin
            state    <= CMP_EVAL;
            mismatch <= 1'b0;
          end
        end
        default: begin
          state    <= CMP_IDLE;
          mismatch <= bad;
          done     <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/owcrc_checker.sv
module owcrc_checker
  import owcrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_crc16,
  input  logic             cfg_tx_en,
  input  logic             cfg_rx_en,
  input  logic             cfg_check,
  input  logic             done_clr,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             bit_dir,
  output logic             stat_crc16,
  output logic             stat_tx_en,
  output logic             stat_rx_en,
  output logic             stat_busy,
  output logic             stat_mismatch,
  output logic             irq_done,
  output logic [CRC_W-1:0] crc_q
);
  logic clr_req, start_req, accept, busy;

  owcrc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_crc16(cfg_crc16),
    .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .cfg_check(cfg_check),
    .bit_vld(bit_vld), .bit_dir(bit_dir), .busy(busy),
    .mode16(stat_crc16), .tx_en(stat_tx_en), .rx_en(stat_rx_en),
    .clr_req(clr_req), .start_req(start_req), .accept(accept)
  );

  owcrc_shift u_shift (
    .clk(clk), .rst(rst), .clr(clr_req), .step(accept), .din(bit_val),
    .mode16(stat_crc16), .crc(crc_q)
  );

  owcrc_cmp u_cmp (
    .clk(clk), .rst(rst), .start(start_req), .mode16(stat_crc16), .crc(crc_q),
    .done_clr(done_clr), .busy(busy), .mismatch(stat_mismatch), .done(irq_done)
  );

  assign stat_busy = busy;
endmodule

// File: rtl/owcrc_checker_sva.sv
module owcrc_checker_sva (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic        done_clr,
  input logic        bit_vld,
  input logic        stat_busy,
  input logic        stat_mismatch,
  input logic        irq_done,
  input logic [15:0] crc_q
);
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stat_busy |=> !stat_busy); // R7
  AST_DONE_AFTER_CMP: assert property (@(posedge clk) disable iff (rst)
    stat_busy |=> irq_done); // R7
  AST_MISMATCH_CLR_START: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_busy) |-> !stat_mismatch); // R8
  AST_MISMATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stat_busy && !$past(stat_busy)) |-> $stable(stat_mismatch)); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (done_clr && !stat_busy) |=> !irq_done); // R9
  AST_CRC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && !cfg_we) |=> $stable(crc_q)); // R4
  AST_CRC_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (stat_busy && !cfg_we) |=> $stable(crc_q)); // R10
endmodule

bind owcrc_checker owcrc_checker_sva u_sva (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .done_clr(done_clr), .bit_vld(bit_vld),
  .stat_busy(stat_busy), .stat_mismatch(stat_mismatch), .irq_done(irq_done),
  .crc_q(crc_q)
);

// File: tb/owcrc_checker_test.sv
module owcrc_checker_test;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_crc16 = 0, cfg_tx_en = 0, cfg_rx_en = 0, cfg_check = 0;
  logic done_clr = 0, bit_vld = 0, bit_val = 0, bit_dir = 0;
  logic stat_crc16, stat_tx_en, stat_rx_en, stat_busy, stat_mismatch, irq_done;
  logic [15:0] crc_q;
  int checks = 0, errors = 0;
  logic [15:0] m;

  always #5 clk = ~clk;

  owcrc_checker uut (.*);

  function automatic logic [15:0] ref_step(logic [15:0] c, logic b, logic w);
    logic fb;
    fb = c[0] ^ b;
    if (w) ref_step = (c >> 1) ^ (fb ? 16'hA001 : 16'h0000);
    else   ref_step = {8'h00, (c[7:0] >> 1) ^ (fb ? 8'h8C : 8'h00)};
  endfunction

  function automatic logic [15:0] ref_byte(logic [15:0] c, logic [7:0] v, logic w);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = ref_step(r, v[i], w);
    ref_byte = r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(logic w, logic tx, logic rx, logic chk);
    @(negedge clk);
    cfg_we = 1; cfg_crc16 = w; cfg_tx_en = tx; cfg_rx_en = rx; cfg_check = chk;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; cfg_check = 0;
  endtask

  task automatic send_bit(logic dir, logic v);
    @(negedge clk);
    bit_vld = 1; bit_dir = dir; bit_val = v;
    @(posedge clk);
    @(negedge clk);
    bit_vld = 0;
  endtask

  task automatic send_byte(logic dir, logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(dir, v[i]);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1", {stat_crc16, stat_tx_en, stat_rx_en, stat_busy, stat_mismatch, irq_done}, 0);
    check("R1", crc_q, 0);

    // R2 / R3 sweep of all byte values in both modes
    for (int w = 0; w < 2; w++) begin
      for (int v = 0; v < 256; v++) begin
        cfg(w[0], 0, 0, 0);
        cfg(w[0], 1, 0, 0);
        send_byte(1, v[7:0]);
        check(w ? "R3" : "R2", crc_q, ref_byte(16'h0, v[7:0], w[0]));
      end
    end

    // R2 / R7 CRC-8 frame with true check byte passes
    cfg(0, 0, 0, 0); cfg(0, 1, 1, 0);
    m = 0;
    send_byte(1, 8'h28); m = ref_byte(m, 8'h28, 0);
    send_byte(0, 8'hC3); m = ref_byte(m, 8'hC3, 0);
    send_byte(0, 8'h7E); m = ref_byte(m, 8'h7E, 0);
    send_byte(0, m[7:0]);
    check("R2", crc_q, 16'h0000);
    cfg(0, 1, 1, 1);
    check("R7 busy", stat_busy, 1);
    @(negedge clk);
    check("R7 busy clears", stat_busy, 0);
    check("R7 done", irq_done, 1);
    check("R7 pass8", stat_mismatch, 0);

    // R9 done clear
    @(negedge clk); done_clr = 1; @(posedge clk); @(negedge clk); done_clr = 0;
    check("R9", irq_done, 0);

    // R3 / R7 CRC-16 frame with inverted check bytes passes
    cfg(1, 0, 0, 0); cfg(1, 1, 0, 0);
    m = 0;
    send_byte(1, 8'h0F); m = ref_byte(m, 8'h0F, 1);
    send_byte(1, 8'hAA); m = ref_byte(m, 8'hAA, 1);
    send_byte(1, 8'h55); m = ref_byte(m, 8'h55, 1);
    check("R3", crc_q, m);
    m = ~m;
    send_byte(1, m[7:0]); send_byte(1, m[15:8]);
    check("R3 residue", crc_q, 16'hB001);
    cfg(1, 1, 0, 1);
    @(negedge clk);
    check("R7 pass16", stat_mismatch, 0);

    // R7 / R8 corrupted frame mismatches, and flag holds
    send_bit(1, 1);
    cfg(1, 1, 0, 1);
    check("R8 clear at start", stat_mismatch, 0);
    @(negedge clk);
    check("R7 fail16", stat_mismatch, 1);
    repeat (3) @(negedge clk);
    check("R8 hold", stat_mismatch, 1);

    // R9 set wins over clear
    @(negedge clk);
    cfg_we = 1; cfg_check = 1; cfg_crc16 = 1; cfg_tx_en = 1; cfg_rx_en = 0;
    @(posedge clk); @(negedge clk); cfg_we = 0; cfg_check = 0; done_clr = 1;
    @(posedge clk); @(negedge clk); done_clr = 0;
    check("R9 set wins", irq_done, 1);

    // R10 strobe during busy is ignored
    m = crc_q;
    @(negedge clk);
    cfg_we = 1; cfg_check = 1;
    @(posedge clk); @(negedge clk); cfg_we = 0; cfg_check = 0;
    bit_vld = 1; bit_dir = 1; bit_val = ~m[0];
    @(posedge clk); @(negedge clk); bit_vld = 0;
    check("R10", crc_q, m);

    // R4 / R5 direction gating
    cfg(1, 0, 0, 0); cfg(1, 1, 0, 0);
    send_byte(1, 8'h9D);
    m = crc_q;
    send_byte(0, 8'hFF);
    check("R5 read blocked", crc_q, m);
    cfg(1, 0, 1, 0);
    check("R6 keep", crc_q, m);
    send_byte(1, 8'hFF);
    check("R4 write blocked", crc_q, m);
    send_byte(0, 8'h3C);
    check("R5 read counted", crc_q, ref_byte(m, 8'h3C, 1));

    // R6 clear when enabling from idle
    cfg(0, 0, 0, 0);
    check("R6 disabled keeps", crc_q, ref_byte(m, 8'h3C, 1));
    cfg(0, 0, 1, 0);
    check("R6 clear", crc_q, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule